// File: doc/BRIEF.md
# Four-Port Out-of-Order Cache Request Queue

This block sits in front of a banked second-level cache. Requests arrive one per cycle, each carrying an address, a read/write flag and an identifier, and wait in a 32-slot pool. Floating-point loads and stores go straight into this pool. They do not pass through the first-level cache.

Every cycle the pool picks up to four requests and sends them to the cache on four issue ports. The choice runs from the oldest request to the youngest. A request is skipped if an older request picked in the same cycle already claims its bank. A request is also skipped if it is a load behind a still-queued older store to the same 16-byte block. A skipped request does not block younger ones, so requests leave the pool out of order.

A picked request leaves the pool at the next clock edge, and its slot can take a new request in that same cycle. The cache can pause all issue with a stall input. While it is paused, requests stay queued and keep their age.

Top module: `l2_issue_queue`

## Requirements
- R1: During reset and in the first cycle after it, every port_valid bit is 0 and alloc_ready is 1.
- R2: alloc_ready is 0 exactly when 32 requests are held. A request offered while alloc_ready is 0 is dropped and never appears on any port.
- R3: Every accepted request appears exactly once, on one port, with its own address, write flag and identifier. It appears no earlier than the cycle after the edge that accepted it.
- R4: Up to four requests issue per cycle. Ports fill from port 0 upward, so port_valid[p] set implies port_valid[p-1] set.
- R5: No two valid ports in the same cycle carry the same bank, where the bank is address bits [7:4].
- R6: Ports are filled in age order. Port 0 takes the oldest eligible request, and each higher port takes a younger request than the port below it.
- R7: A request whose bank is taken by an older pick waits. Younger requests to free banks issue ahead of it in that cycle.
- R8: A load does not issue while an older store with equal address bits [31:4] is still queued.
- R9: An issued slot is free from the next cycle. A request is accepted in a cycle in which other requests issue.
- R10: While issue_stall is 1, no port is valid. Queued requests keep their contents and their order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | New request offered |
| alloc_ready | output | 1 | A free slot exists |
| alloc_addr | input | 32 | Request byte address |
| alloc_write | input | 1 | 1 = store, 0 = load |
| alloc_id | input | 6 | Request identifier |
| issue_stall | input | 1 | Cache cannot take requests this cycle |
| port_valid | output | 4 | One bit per issue port |
| port_addr | output | 128 | Address per port, port p at bits [32p+31:32p] |
| port_write | output | 4 | Write flag per port |
| port_id | output | 24 | Identifier per port, port p at bits [6p+5:6p] |

## Verification
Allocation and retirement can fall in the same cycle, and the case that matters is a completely full pool. To provoke it, the bench fills all 32 slots while issue is stalled, then offers a request that must be dropped. It then releases the stall. One cycle later, while four more requests are still leaving, it offers a new request. The result is judged on alloc_ready in each of those cycles, and on a per-identifier count of appearances on the ports: every original request and the late arrival appear once, and the dropped request never does.

// File: rtl/l2_issue_queue.sv
module l2_issue_queue #(
  parameter int DEPTH    = 32,
  parameter int PORTS    = 4,
  parameter int ADDR_W   = 32,
  parameter int ID_W     = 6,
  parameter int BANK_LSB = 4,
  parameter int BANK_W   = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    alloc_valid,
  output logic                    alloc_ready,
  input  logic [ADDR_W-1:0]       alloc_addr,
  input  logic                    alloc_write,
  input  logic [ID_W-1:0]         alloc_id,
  input  logic                    issue_stall,
  output logic [PORTS-1:0]        port_valid,
  output logic [PORTS*ADDR_W-1:0] port_addr,
  output logic [PORTS-1:0]        port_write,
  output logic [PORTS*ID_W-1:0]   port_id
);

  localparam int NBANK = 1 << BANK_W;

  logic [DEPTH-1:0]  valid_q;
  logic [DEPTH-1:0]  wr_q;
  logic [ADDR_W-1:0] addr_q  [DEPTH];
  logic [ID_W-1:0]   id_q    [DEPTH];
  logic [DEPTH-1:0]  older_q [DEPTH];

  logic [BANK_W-1:0] bank [DEPTH];
  logic [DEPTH-1:0]  hazard, avail, picked, cand;
  logic [DEPTH-1:0]  sel [PORTS];
  logic [NBANK-1:0]  busy;
  logic [DEPTH-1:0]  free, alloc_oh;
  logic              accept;

  assign free        = ~valid_q;
  assign alloc_oh    = free & (~free + DEPTH'(1));
  assign alloc_ready = |free;
  assign accept      = alloc_valid & alloc_ready;

  for (genvar i = 0; i < DEPTH; i++) begin : g_bank
    assign bank[i] = addr_q[i][BANK_LSB +: BANK_W];
  end

  always_comb begin
    hazard = '0;
    for (int i = 0; i < DEPTH; i++)
      for (int j = 0; j < DEPTH; j++)
        if (older_q[i][j] && valid_q[j] && wr_q[j] && !wr_q[i] &&
            addr_q[i][ADDR_W-1:BANK_LSB] == addr_q[j][ADDR_W-1:BANK_LSB])
          hazard[i] = 1'b1;
  end

  assign avail = valid_q & ~hazard & {DEPTH{~issue_stall}};

  always_comb begin
    picked = '0;
    busy   = '0;
    cand   = '0;
    for (int p = 0; p < PORTS; p++) begin
      cand = avail & ~picked;
      for (int i = 0; i < DEPTH; i++)
        if (busy[bank[i]]) cand[i] = 1'b0;
      sel[p] = '0;
      for (int i = 0; i < DEPTH; i++)
        sel[p][i] = cand[i] & ~|(older_q[i] & cand);
      picked = picked | sel[p];
      for (int i = 0; i < DEPTH; i++)
        if (sel[p][i]) busy[bank[i]] = 1'b1;
    end
  end

  always_comb begin
    port_addr  = '0;
    port_id    = '0;
    port_write = '0;
    for (int p = 0; p < PORTS; p++) begin
      port_valid[p] = |sel[p];
      for (int i = 0; i < DEPTH; i++)
        if (sel[p][i]) begin
          port_addr[p*ADDR_W +: ADDR_W] = port_addr[p*ADDR_W +: ADDR_W] | addr_q[i];
          port_id[p*ID_W +: ID_W]       = port_id[p*ID_W +: ID_W] | id_q[i];
          port_write[p]                 = port_write[p] | wr_q[i];
        end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      for (int i = 0; i < DEPTH; i++) older_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++)
        if (picked[i]) valid_q[i] <= 1'b0;
      for (int j = 0; j < DEPTH; j++)
        if (accept && alloc_oh[j])
          for (int i = 0; i < DEPTH; i++) older_q[i][j] <= 1'b0;
      for (int i = 0; i < DEPTH; i++)
        if (accept && alloc_oh[i]) begin
          valid_q[i] <= 1'b1;
          older_q[i] <= valid_q & ~picked;
        end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++)
      if (accept && alloc_oh[i]) begin
        addr_q[i] <= alloc_addr;
        id_q[i]   <= alloc_id;
        wr_q[i]   <= alloc_write;
      end
  end

endmodule

// File: rtl/l2_issue_queue_chk.sv
module l2_issue_queue_chk #(
  parameter int DEPTH    = 32,
  parameter int PORTS    = 4,
  parameter int ADDR_W   = 32,
  parameter int ID_W     = 6,
  parameter int BANK_LSB = 4,
  parameter int BANK_W   = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    alloc_valid,
  input logic                    alloc_ready,
  input logic [ADDR_W-1:0]       alloc_addr,
  input logic                    alloc_write,
  input logic [ID_W-1:0]         alloc_id,
  input logic                    issue_stall,
  input logic [PORTS-1:0]        port_valid,
  input logic [PORTS*ADDR_W-1:0] port_addr,
  input logic [PORTS-1:0]        port_write,
  input logic [PORTS*ID_W-1:0]   port_id
);

  localparam int OCC_W = $clog2(DEPTH + 1);

  logic [OCC_W-1:0] occ;

  always_ff @(posedge clk) begin
    if (!rst_n) occ <= '0;
    else occ <= occ + OCC_W'(alloc_valid && alloc_ready)
                    - OCC_W'($countones(port_valid));
  end

  p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (port_valid == '0 && alloc_ready));

  p_ready_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_ready == (occ != OCC_W'(DEPTH)));

  p_no_phantom_r3: assert property (@(posedge clk) disable iff (!rst_n)
    OCC_W'($countones(port_valid)) <= occ);

  p_stall_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    issue_stall |-> port_valid == '0);

  for (genvar p = 1; p < PORTS; p++) begin : g_pack
    p_ports_packed_r4: assert property (@(posedge clk) disable iff (!rst_n)
      port_valid[p] |-> port_valid[p-1]);
  end

  for (genvar p = 0; p < PORTS; p++) begin : g_pa
    for (genvar q = p + 1; q < PORTS; q++) begin : g_pb
      p_bank_unique_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (port_valid[p] && port_valid[q]) |->
        port_addr[p*ADDR_W+BANK_LSB +: BANK_W] != port_addr[q*ADDR_W+BANK_LSB +: BANK_W]);
    end
  end

endmodule

bind l2_issue_queue l2_issue_queue_chk #(
  .DEPTH(DEPTH), .PORTS(PORTS), .ADDR_W(ADDR_W), .ID_W(ID_W),
  .BANK_LSB(BANK_LSB), .BANK_W(BANK_W)
) u_chk (.*);

// File: tb/tb_l2_issue_queue.sv
module tb_l2_issue_queue;
  localparam int PORTS = 4, ADDR_W = 32, ID_W = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic alloc_valid = 1'b0, alloc_write = 1'b0, issue_stall = 1'b0;
  logic alloc_ready;
  logic [ADDR_W-1:0] alloc_addr = '0;
  logic [ID_W-1:0] alloc_id = '0;
  logic [PORTS-1:0] port_valid, port_write;
  logic [PORTS*ADDR_W-1:0] port_addr;
  logic [PORTS*ID_W-1:0] port_id;

  int n_chk = 0, n_err = 0;
  int seen [64];
  bit done = 1'b0;

  always #5 clk = ~clk;

  l2_issue_queue dut (.*);

  always @(negedge clk)
    for (int p = 0; p < PORTS; p++)
      if (rst_n && port_valid[p]) seen[port_id[p*ID_W +: ID_W]]++;

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int pid(input int p);
    return int'(port_id[p*ID_W +: ID_W]);
  endfunction

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic clear_seen();
    for (int k = 0; k < 64; k++) seen[k] = 0;
  endtask

  task automatic push(input logic [31:0] a, input logic w, input int id);
    alloc_valid = 1'b1; alloc_addr = a; alloc_write = w; alloc_id = ID_W'(id);
    step();
    alloc_valid = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 valid in reset", port_valid, 0);
    check("R1 ready in reset", alloc_ready, 1);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid after reset", port_valid, 0);
    check("R1 ready after reset", alloc_ready, 1);
    step();
  endtask

  task automatic t_single();
    alloc_valid = 1'b1; alloc_addr = 32'h0000_0A50; alloc_write = 1'b1; alloc_id = 6'd5;
    @(negedge clk);
    check("R3 not before accept", port_valid, 0);
    step();
    alloc_valid = 1'b0;
    @(negedge clk);
    check("R3 single valid", port_valid, 4'b0001);
    check("R3 single addr", port_addr[31:0], 32'h0000_0A50);
    check("R3 single write", port_write[0], 1);
    check("R3 single id", pid(0), 5);
    step();
    @(negedge clk);
    check("R9 slot retired", port_valid, 0);
    step();
  endtask

  task automatic t_four_banks();
    issue_stall = 1'b1;
    for (int k = 0; k < 6; k++) push(32'h100 + 32'(k) * 16, 1'b0, k + 1);
    @(negedge clk);
    check("R10 stalled ports", port_valid, 0);
    step();
    issue_stall = 1'b0;
    @(negedge clk);
    check("R4 four ports", port_valid, 4'b1111);
    for (int p = 0; p < 4; p++) check("R6 age order", pid(p), p + 1);
    step();
    @(negedge clk);
    check("R4 low ports first", port_valid, 4'b0011);
    check("R6 port0 second wave", pid(0), 5);
    check("R6 port1 second wave", pid(1), 6);
    step();
    @(negedge clk);
    check("R9 drained", port_valid, 0);
    step();
  endtask

  task automatic t_conflict();
    issue_stall = 1'b1;
    push(32'h030, 1'b0, 10);
    push(32'h130, 1'b0, 11);
    push(32'h070, 1'b0, 12);
    push(32'h230, 1'b0, 13);
    push(32'h080, 1'b0, 14);
    issue_stall = 1'b0;
    @(negedge clk);
    check("R5 first wave valid", port_valid, 4'b0111);
    check("R7 port0", pid(0), 10);
    check("R7 younger passes p1", pid(1), 12);
    check("R7 younger passes p2", pid(2), 14);
    step();
    @(negedge clk);
    check("R5 second wave valid", port_valid, 4'b0001);
    check("R7 waiter id", pid(0), 11);
    step();
    @(negedge clk);
    check("R5 third wave valid", port_valid, 4'b0001);
    check("R7 last waiter", pid(0), 13);
    step();
  endtask

  task automatic t_order();
    issue_stall = 1'b1;
    push(32'h1230, 1'b1, 20);
    push(32'h1238, 1'b0, 21);
    push(32'h2240, 1'b0, 22);
    push(32'h3350, 1'b0, 23);
    issue_stall = 1'b0;
    @(negedge clk);
    check("R8 first wave", port_valid, 4'b0111);
    check("R8 store first", pid(0), 20);
    check("R8 store flag", port_write[0], 1);
    check("R8 other load", pid(1), 22);
    check("R8 other load 2", pid(2), 23);
    step();
    @(negedge clk);
    check("R8 load after store", port_valid, 4'b0001);
    check("R8 held load id", pid(0), 21);
    check("R8 held load addr", port_addr[31:0], 32'h1238);
    step();
  endtask

  task automatic t_full();
    int bad;
    clear_seen();
    issue_stall = 1'b1;
    for (int k = 0; k < 32; k++) push(32'(k) * 16, 1'b0, k);
    @(negedge clk);
    check("R2 full ready low", alloc_ready, 0);
    step();
    alloc_valid = 1'b1; alloc_addr = 32'h4000; alloc_id = 6'd40; alloc_write = 1'b0;
    step();
    alloc_valid = 1'b0;
    issue_stall = 1'b0;
    @(negedge clk);
    check("R2 still full while issuing", alloc_ready, 0);
    for (int p = 0; p < 4; p++) check("R6 full wave 1", pid(p), p);
    step();
    alloc_valid = 1'b1; alloc_addr = 32'h5000; alloc_id = 6'd42;
    @(negedge clk);
    check("R9 freed next cycle", alloc_ready, 1);
    check("R9 issue same cycle", port_valid, 4'b1111);
    for (int p = 0; p < 4; p++) check("R6 full wave 2", pid(p), p + 4);
    step();
    alloc_valid = 1'b0;
    repeat (14) step();
    bad = 0;
    for (int k = 0; k < 32; k++) if (seen[k] != 1) bad++;
    check("R3 each once", bad, 0);
    check("R2 dropped never issued", seen[40], 0);
    check("R9 late arrival issued", seen[42], 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    clear_seen();
    t_reset();
    t_single();
    t_four_banks();
    t_conflict();
    t_order();
    t_full();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule